// File: doc/BRIEF.md
# Flash Write Key-Lock Sequencer

This block sits between a CPU register port and a flash programming interface and decides whether a memory-write strobe may become a flash programming request. The CPU writes two fixed key bytes, in a fixed order, to a key register. Only after both keys have arrived may one data write pass to flash, and only while the control register has write-enable set and erase-enable clear. Each granted write re-locks the sequencer at once, so software repeats the key pair before every byte it programs. The target page is assumed to have been erased beforehand; erase, cell timing and bank selection are handled elsewhere.

A wrong key value, a key written out of turn, or a programming write attempted without a full unlock sets a lock-error flag. The flag stays set until reset, and while it is set no flash request can be issued. A granted write becomes a one-cycle request pulse that carries the latched address and data. A busy signal then stays high until the flash side acknowledges.

Top module: `flash_keylock`

## Requirements
- R1: After reset, key_state is 0 (locked), lock_err is 0, flash_req is 0 and busy is 0.
- R2: With no error, a key write of 0xA5 in state 0 moves key_state to 1 (first key seen). A key write of 0xF1 in state 1 then moves it to 2 (unlocked). The new state is visible the cycle after the key write.
- R3: A key write in state 0 other than 0xA5, or in state 1 other than 0xF1, sets lock_err and returns key_state to 0. lock_err then stays 1 until reset.
- R4: A key write while key_state is 2 is out of order: it sets lock_err and returns key_state to 0.
- R5: A memory write with control bit 0 (write enable) at 1 and control bit 1 (erase enable) at 0, while key_state is 2, busy is 0 and lock_err is 0, raises flash_req for exactly one cycle. This is the cycle after the strobe. flash_addr and flash_data then carry the strobe's address and data, and key_state returns to 0.
- R6: Each unlock covers one write. A second memory write with the same control setting and no new key pair issues no request and sets lock_err.
- R7: A memory write while write enable is 0 issues no request, leaves lock_err unchanged and leaves key_state unchanged.
- R8: A memory write while both write enable and erase enable are 1 issues no request, sets no error and keeps key_state unchanged.
- R9: A memory write with write enable 1 and erase enable 0 in key_state 0 or 1 issues no request and sets lock_err.
- R10: busy rises together with flash_req and stays 1 until the cycle after flash_ack is sampled high. A programming write during busy is dropped and sets lock_err.
- R11: While lock_err is 1, key_state stays 0 even for a correct key pair, and no flash request is issued.
- R12: Control writes select reg_sel = 1, with bit 0 as write enable and bit 1 as erase enable. Key writes select reg_sel = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | CPU register write strobe |
| reg_sel | input | 1 | 0 selects the key register, 1 selects the control register |
| reg_wdata | input | 8 | Register write data |
| mem_wr | input | 1 | Memory-write strobe |
| mem_addr | input | ADDR_W | Memory-write address |
| mem_wdata | input | DATA_W | Memory-write data |
| flash_ack | input | 1 | Flash interface completion |
| flash_req | output | 1 | One-cycle programming request |
| flash_addr | output | ADDR_W | Latched request address |
| flash_data | output | DATA_W | Latched request data |
| busy | output | 1 | Request outstanding |
| key_state | output | 2 | 0 locked, 1 first key seen, 2 unlocked |
| lock_err | output | 1 | Sticky lock-error flag |

## Verification
On every cycle, the assertions check the following:
- the request is a single pulse and coincides with the re-lock;
- the error flag never clears without reset and holds the key state at locked;
- busy holds until an acknowledge and drops right after one;
- a request only follows a cycle in which write enable was set and erase enable was clear.

Only the bench scenarios can show which key values advance the state and that every wrong value is caught. They also show the latched address and data, and that a disabled or erase-mode strobe leaves the unlock intact for a later write. The bench sweeps every key byte in both positions and runs programming writes against several acknowledge delays.

// File: rtl/flk_pkg.sv
package flk_pkg;
   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_FIRST  = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_t;

   localparam int CTRL_WEN_BIT = 0;
   localparam int CTRL_EEN_BIT = 1;
endpackage

// File: rtl/flk_key_fsm.sv
module flk_key_fsm
   import flk_pkg::*;
#(
   parameter int            KEY_W      = 8,
   parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hA5,
   parameter logic [KEY_W-1:0] KEY_SECOND = 8'hF1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key_val,
   input  logic             consume,
   input  logic             mem_fault,
   output key_state_t       state,
   output logic             err
);
   key_state_t st_n;
   logic       err_n;

   always_comb begin
      st_n  = state;
      err_n = err | mem_fault;
      if (key_wr && !err) begin
         unique case (state)
            KS_LOCKED: if (key_val == KEY_FIRST)  st_n = KS_FIRST; else err_n = 1'b1;
            KS_FIRST:  if (key_val == KEY_SECOND) st_n = KS_OPEN;  else err_n = 1'b1;
            default:   err_n = 1'b1;
         endcase
      end
      if (consume) st_n = KS_LOCKED;
      if (err_n)   st_n = KS_LOCKED;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= KS_LOCKED;
         err   <= 1'b0;
      end else begin
         state <= st_n;
         err   <= err_n;
      end
   end

   // R3: error flag is sticky
   p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   // R11: error holds the key state at locked
   p_err_locks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> state == KS_LOCKED);
   // R2: the unlocked state is reached only from first-key-seen
   p_open_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == KS_OPEN && $past(state) != KS_OPEN) |-> $past(state) == KS_FIRST);
endmodule

// File: rtl/flk_req_gen.sv
module flk_req_gen #(
   parameter int ADDR_W       = 10,
   parameter int DATA_W       = 8,
   parameter bit CLEAR_ON_ACK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic              ack,
   output logic              req,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic              busy
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req  <= 1'b0;
         busy <= 1'b0;
      end else begin
         req <= grant;
         if (grant)     busy <= 1'b1;
         else if (ack)  busy <= 1'b0;
      end
   end

   generate
      if (CLEAR_ON_ACK) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               addr_q <= '0;
               data_q <= '0;
            end else if (grant) begin
               addr_q <= addr_in;
               data_q <= data_in;
            end else if (busy && ack) begin
               addr_q <= '0;
               data_q <= '0;
            end
         end
      end else begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               addr_q <= '0;
               data_q <= '0;
            end else if (grant) begin
               addr_q <= addr_in;
               data_q <= data_in;
            end
         end
      end
   endgenerate

   // R5: request lasts one cycle
   p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req);
   // R10: busy accompanies the request
   p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> busy);
   // R10: busy holds until acknowledged
   p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ack) |=> busy);
   // R10: busy drops after acknowledge
   p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ack) |=> !busy);
endmodule

// File: rtl/flash_keylock.sv
module flash_keylock
   import flk_pkg::*;
#(
   parameter int ADDR_W       = 10,
   parameter int DATA_W       = 8,
   parameter int PAGE_BYTES   = 512,
   parameter bit CLEAR_ON_ACK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [7:0]        reg_wdata,
   input  logic              mem_wr,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_wdata,
   input  logic              flash_ack,
   output logic              flash_req,
   output logic [ADDR_W-1:0] flash_addr,
   output logic [DATA_W-1:0] flash_data,
   output logic              busy,
   output logic [1:0]        key_state,
   output logic              lock_err
);
   localparam int PAGE_AW = $clog2(PAGE_BYTES);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
      if (ADDR_W < PAGE_AW) begin : g_bad_addr
         $error("ADDR_W must cover one page");
      end
      if ((1 << PAGE_AW) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
   endgenerate

   logic [1:0] ctrl_q;
   key_state_t ks;
   logic       err;
   logic       prog_mode, attempt, grant, fault, key_wr;

   always_ff @(posedge clk) begin
      if (!rst_n)                 ctrl_q <= '0;
      else if (reg_wr && reg_sel) ctrl_q <= reg_wdata[1:0];
   end

   assign key_wr    = reg_wr && !reg_sel;
   assign prog_mode = ctrl_q[CTRL_WEN_BIT] && !ctrl_q[CTRL_EEN_BIT];
   assign attempt   = mem_wr && prog_mode;
   assign grant     = attempt && (ks == KS_OPEN) && !err && !busy;
   assign fault     = attempt && !grant;

   flk_key_fsm #(
      .KEY_W      (8),
      .KEY_FIRST  (8'hA5),
      .KEY_SECOND (8'hF1)
   ) u_keys (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_wr    (key_wr),
      .key_val   (reg_wdata),
      .consume   (grant),
      .mem_fault (fault),
      .state     (ks),
      .err       (err)
   );

   flk_req_gen #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .CLEAR_ON_ACK (CLEAR_ON_ACK)
   ) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant   (grant),
      .addr_in (mem_addr),
      .data_in (mem_wdata),
      .ack     (flash_ack),
      .req     (flash_req),
      .addr_q  (flash_addr),
      .data_q  (flash_data),
      .busy    (busy)
   );

   assign key_state = ks;
   assign lock_err  = err;

   // R6: a request always coincides with the re-lock
   p_single_use_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flash_req |-> key_state == 2'd0);
   // R7 / R8: a request only follows a programming-mode cycle
   p_prog_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flash_req |-> ($past(ctrl_q[CTRL_WEN_BIT]) && !$past(ctrl_q[CTRL_EEN_BIT])));
   // R11: no request once the error flag was already set
   p_no_req_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
      lock_err |=> !flash_req);
endmodule

// File: tb/sim_flash_keylock.sv
module sim_flash_keylock;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_sel = 1'b0;
   logic [7:0]    reg_wdata = '0;
   logic          mem_wr = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic [DW-1:0] mem_wdata = '0;
   logic          flash_ack = 1'b0;
   logic          flash_req, busy, lock_err;
   logic [AW-1:0] flash_addr;
   logic [DW-1:0] flash_data;
   logic [1:0]    key_state;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_keylock u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .flash_ack(flash_ack), .flash_req(flash_req),
      .flash_addr(flash_addr), .flash_data(flash_data), .busy(busy),
      .key_state(key_state), .lock_err(lock_err)
   );

   task automatic check(string rq, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic key(input logic [7:0] v);
      @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = v;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic ctrl(input logic [1:0] v);
      @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = {6'd0, v};
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic mwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk); mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
      @(negedge clk); mem_wr = 1'b0;
   endtask

   task automatic ack_pulse();
      @(negedge clk); flash_ack = 1'b1;
      @(negedge clk); flash_ack = 1'b0;
   endtask

   initial begin
      do_reset();
      check("R1 state", key_state, 0);
      check("R1 err", lock_err, 0);
      check("R1 req", flash_req, 0);
      check("R1 busy", busy, 0);

      // R2 / R3: every value in the first key position
      for (int v = 0; v < 256; v++) begin
         do_reset();
         key(v[7:0]);
         check("R2 first state", key_state, (v == 8'hA5) ? 1 : 0);
         check("R3 first err", lock_err, (v == 8'hA5) ? 0 : 1);
      end
      // R2 / R3: every value in the second key position
      for (int v = 0; v < 256; v++) begin
         do_reset();
         key(8'hA5);
         key(v[7:0]);
         check("R2 second state", key_state, (v == 8'hF1) ? 2 : 0);
         check("R3 second err", lock_err, (v == 8'hF1) ? 0 : 1);
      end
      // R3 stickiness
      key(8'hA5);
      ctrl(2'b01);
      check("R3 sticky", lock_err, 1);

      // R4: key write while unlocked
      do_reset();
      key(8'hA5); key(8'hF1);
      key(8'hA5);
      check("R4 err", lock_err, 1);
      check("R4 state", key_state, 0);

      // R5 / R10 / R12: programming writes with varied ack delay
      do_reset();
      ctrl(2'b01);
      for (int i = 0; i < 16; i++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         a = AW'((i * 37 + 5) % 1024);
         d = DW'(i * 11 + 3);
         key(8'hA5); key(8'hF1);
         check("R2 open", key_state, 2);
         mwrite(a, d);
         check("R5 req", flash_req, 1);
         check("R5 addr", flash_addr, a);
         check("R5 data", flash_data, d);
         check("R5 relock", key_state, 0);
         check("R10 busy up", busy, 1);
         @(negedge clk);
         check("R5 pulse", flash_req, 0);
         for (int k = 0; k < i % 4; k++) begin
            check("R10 busy hold", busy, 1);
            @(negedge clk);
         end
         ack_pulse();
         check("R10 busy down", busy, 0);
         check("R5 no err", lock_err, 0);
      end
      // R6: no second write from one unlock
      mwrite(10'd7, 8'h55);
      check("R6 no req", flash_req, 0);
      check("R6 err", lock_err, 1);

      // R7: write enable clear
      do_reset();
      key(8'hA5); key(8'hF1);
      mwrite(10'd3, 8'h12);
      check("R7 no req", flash_req, 0);
      check("R7 no err", lock_err, 0);
      check("R7 state", key_state, 2);
      ctrl(2'b01);
      mwrite(10'd4, 8'h34);
      check("R7 later req", flash_req, 1);
      check("R7 later data", flash_data, 8'h34);
      ack_pulse();

      // R8: erase enable set
      do_reset();
      key(8'hA5); key(8'hF1);
      ctrl(2'b11);
      mwrite(10'd9, 8'h77);
      check("R8 no req", flash_req, 0);
      check("R8 no err", lock_err, 0);
      check("R8 state", key_state, 2);

      // R9: write without full unlock
      do_reset();
      ctrl(2'b01);
      mwrite(10'd1, 8'h01);
      check("R9 locked req", flash_req, 0);
      check("R9 locked err", lock_err, 1);
      do_reset();
      ctrl(2'b01);
      key(8'hA5);
      mwrite(10'd1, 8'h01);
      check("R9 half req", flash_req, 0);
      check("R9 half err", lock_err, 1);

      // R10: write during busy
      do_reset();
      ctrl(2'b01);
      key(8'hA5); key(8'hF1);
      mwrite(10'd2, 8'h22);
      key(8'hA5); key(8'hF1);
      check("R10 still busy", busy, 1);
      mwrite(10'd3, 8'h33);
      check("R10 busy no req", flash_req, 0);
      check("R10 busy err", lock_err, 1);
      check("R10 payload kept", flash_data, 8'h22);
      ack_pulse();

      // R11: correct keys after an error
      do_reset();
      ctrl(2'b01);
      key(8'h00);
      key(8'hA5);
      check("R11 state a", key_state, 0);
      key(8'hF1);
      check("R11 state b", key_state, 0);
      mwrite(10'd5, 8'h66);
      check("R11 no req", flash_req, 0);
      check("R11 busy", busy, 0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule